// File: doc/BRIEF.md
# Peripheral Power and Clock Gating Controller

This block decides, for a single peripheral, whether that peripheral is powered and whether it is clocked. It looks at the device operating mode and at three per-mode clock-gating enables, and it picks the enable that belongs to the current mode. A separate keep-power bit then chooses what happens when the selected enable is clear. With the bit clear the peripheral is switched fully off and its state is lost. With the bit set the peripheral keeps power but gets no clock, so it draws only leakage current and keeps its state.

The four control bits sit in four word registers behind a simple write-strobe and read-mux bus. The block drives a power-enable, a clock-enable and an isolation request. It also drives a one-cycle peripheral reset pulse. The pulse fires whenever the peripheral goes from unpowered to powered, because the peripheral must then be re-initialised. That transition can come from a mode change, from a gating bit being set, or from the keep-power bit being written from 0 to 1. All outputs are registered.

Top module: `pgc_top`

## Requirements
- R1: Mode encoding on `mode_i` is 2'b00 Run, 2'b01 Sleep, 2'b10 Deep-Sleep, and 2'b11 behaves as Run. The selected gating bit is the Run bit (offset 0x0) in Run, the Sleep bit (offset 0x4) in Sleep and the Deep-Sleep bit (offset 0x8) in Deep-Sleep.
- R2: When the selected gating bit is 1, `pwr_en_o` and `clk_en_o` are both 1, regardless of the keep-power bit.
- R3: When the selected gating bit is 0 and the keep-power bit (offset 0xC) is 0, `pwr_en_o` and `clk_en_o` are both 0.
- R4: When the selected gating bit is 0 and the keep-power bit is 1, `pwr_en_o` is 1 and `clk_en_o` is 0.
- R5: The outputs are registered. A change on `mode_i` first shows on `pwr_en_o`/`clk_en_o` after the next rising clock edge, and does not show before it.
- R6: `prst_o` is 1 for exactly one cycle, in the cycle after the one in which `pwr_en_o` rose. It is never 1 at any other time.
- R7: `iso_o` is 1 in every cycle in which `pwr_en_o` is 0. It stays 1 in the first cycle after `pwr_en_o` rises and falls to 0 one cycle later.
- R8: Each register holds its control bit in bit 0, at byte offsets 0x0, 0x4, 0x8 and 0xC. Bits 31:1 read as zero, and writes to them are ignored. A write to one register leaves the others unchanged.
- R9: After reset the three gating bits read 0 and the keep-power register reads 0x0000_0001. The outputs then show `pwr_en_o`=1, `clk_en_o`=0, `iso_o`=0 and `prst_o`=0.
- R10: Writing the keep-power bit from 0 to 1 while the selected gating bit is 0 powers the peripheral and produces the reset pulse of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_i | input | 2 | Device operating mode |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| pwr_en_o | output | 1 | Peripheral power enable |
| clk_en_o | output | 1 | Peripheral clock enable |
| iso_o | output | 1 | Isolation request for the peripheral's outputs |
| prst_o | output | 1 | One-cycle peripheral reset pulse |

## Verification
The hardest situation to reach is a power-up edge caused by a change of mode alone, with the registers left untouched. Reaching it needs a register setting in which the old mode selects a cleared gating bit, the new mode selects a set one, and the keep-power bit is clear. The bench first settles every combination of gating bits and keep-power bit under one mode, then switches `mode_i` at a single edge to each of the four mode codes. It follows that edge and the two cycles after it, checking the unchanged outputs before the edge, the new enables, the isolation release and the presence or absence of the pulse. A separate sweep makes the keep-power write the only cause of power-up.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_SLEEP = 2'b01,
    MODE_DEEP  = 2'b10,
    MODE_ALT   = 2'b11
  } pgc_mode_e;

  // Word indices (byte offset >> 2) of the control registers.
  localparam int unsigned IDX_GATE_RUN   = 0;
  localparam int unsigned IDX_GATE_SLEEP = 1;
  localparam int unsigned IDX_GATE_DEEP  = 2;
  localparam int unsigned IDX_KEEP_PWR   = 3;
  localparam int unsigned N_GATES        = 3;

  typedef struct packed {
    logic [N_GATES-1:0] gate;     // [0] run, [1] sleep, [2] deep-sleep
    logic               keep_pwr;
  } pgc_ctl_t;

endpackage

// File: rtl/pgc_rst_sync.sv
module pgc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pgc_regs.sv
module pgc_regs
  import pgc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output pgc_ctl_t          ctl_o
);

  localparam int unsigned IDX_W  = 2;
  localparam int unsigned N_REGS = N_GATES + 1;

  logic [IDX_W-1:0] word_idx;
  logic             wbit;
  logic [N_REGS-1:0] wr_hit;
  logic [N_REGS-1:0] bit_q;
  logic [N_REGS-1:0] bit_d;
  logic             unused_bus_bits;

  assign word_idx        = addr_i[IDX_W+1:2];
  assign wbit            = wdata_i[0];
  assign unused_bus_bits = ^{addr_i[1:0], wdata_i[DATA_W-1:1]};

  genvar gi;
  generate
    for (gi = 0; gi < N_REGS; gi++) begin : g_reg
      localparam logic RST_VAL = (gi == IDX_KEEP_PWR) ? 1'b1 : 1'b0;

      always_comb begin
        wr_hit[gi] = wr_i && (word_idx == IDX_W'(gi));
        bit_d[gi]  = wr_hit[gi] ? wbit : bit_q[gi];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bit_q[gi] <= RST_VAL;
        end else if (wr_hit[gi]) begin
          bit_q[gi] <= bit_d[gi];
        end
      end
    end
  endgenerate

  always_comb begin
    rdata_o    = '0;
    rdata_o[0] = bit_q[word_idx];
  end

  always_comb begin
    ctl_o.gate[0]  = bit_q[IDX_GATE_RUN];
    ctl_o.gate[1]  = bit_q[IDX_GATE_SLEEP];
    ctl_o.gate[2]  = bit_q[IDX_GATE_DEEP];
    ctl_o.keep_pwr = bit_q[IDX_KEEP_PWR];
  end

endmodule

// File: rtl/pgc_policy.sv
module pgc_policy
  import pgc_pkg::*;
(
  input  logic [1:0] mode_i,
  input  pgc_ctl_t   ctl_i,
  output logic       gate_sel_o,
  output logic       pwr_nx_o,
  output logic       clk_nx_o
);

  always_comb begin
    unique case (pgc_mode_e'(mode_i))
      MODE_SLEEP: gate_sel_o = ctl_i.gate[1];
      MODE_DEEP:  gate_sel_o = ctl_i.gate[2];
      default:    gate_sel_o = ctl_i.gate[0];
    endcase
  end

  always_comb begin
    pwr_nx_o = gate_sel_o || ctl_i.keep_pwr;
    clk_nx_o = gate_sel_o;
  end

endmodule

// File: rtl/pgc_outreg.sv
module pgc_outreg (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_nx_i,
  input  logic clk_nx_i,
  output logic pwr_en_o,
  output logic clk_en_o,
  output logic iso_o,
  output logic prst_o
);

  logic pwr_q, clk_q, iso_q, prst_q, pwr_prev_q;
  logic pwr_d, clk_d, iso_d, prst_d, pwr_prev_d;

  always_comb begin
    pwr_d      = pwr_nx_i;
    clk_d      = clk_nx_i;
    // Isolate from the same edge that removes power; release a cycle late.
    iso_d      = !pwr_nx_i || !pwr_q;
    // Pulse in the cycle following a rise of the registered power enable.
    prst_d     = pwr_q && !pwr_prev_q;
    pwr_prev_d = pwr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q      <= 1'b1;
      clk_q      <= 1'b0;
      iso_q      <= 1'b0;
      prst_q     <= 1'b0;
      pwr_prev_q <= 1'b1;
    end else begin
      pwr_q      <= pwr_d;
      clk_q      <= clk_d;
      iso_q      <= iso_d;
      prst_q     <= prst_d;
      pwr_prev_q <= pwr_prev_d;
    end
  end

  assign pwr_en_o = pwr_q;
  assign clk_en_o = clk_q;
  assign iso_o    = iso_q;
  assign prst_o   = prst_q;

endmodule

// File: rtl/pgc_top.sv
module pgc_top
  import pgc_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              pwr_en_o,
  output logic              clk_en_o,
  output logic              iso_o,
  output logic              prst_o
);

  logic     sys_rst_n;
  pgc_ctl_t ctl_q;
  logic     gate_sel;
  logic     pwr_nx;
  logic     clk_nx;

  pgc_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (sys_rst_n)
  );

  pgc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .ctl_o   (ctl_q)
  );

  pgc_policy u_policy (
    .mode_i     (mode_i),
    .ctl_i      (ctl_q),
    .gate_sel_o (gate_sel),
    .pwr_nx_o   (pwr_nx),
    .clk_nx_o   (clk_nx)
  );

  pgc_outreg u_out (
    .clk      (clk),
    .rst_n    (sys_rst_n),
    .pwr_nx_i (pwr_nx),
    .clk_nx_i (clk_nx),
    .pwr_en_o (pwr_en_o),
    .clk_en_o (clk_en_o),
    .iso_o    (iso_o),
    .prst_o   (prst_o)
  );

endmodule

// File: rtl/pgc_checker.sv
module pgc_checker
  import pgc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input pgc_ctl_t   ctl_q,
  input logic       pwr_en_o,
  input logic       clk_en_o,
  input logic       iso_o,
  input logic       prst_o
);

  logic want;
  always_comb begin
    if (mode_i == 2'b01)      want = ctl_q.gate[1];
    else if (mode_i == 2'b10) want = ctl_q.gate[2];
    else                      want = ctl_q.gate[0];
  end

  AST_GATE_ON_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    want |=> (pwr_en_o && clk_en_o)); // R2

  AST_OFF_WITHOUT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!want && !ctl_q.keep_pwr) |=> (!pwr_en_o && !clk_en_o)); // R3

  AST_KEEP_UNCLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!want && ctl_q.keep_pwr) |=> (pwr_en_o && !clk_en_o)); // R4

  AST_ISO_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en_o |-> iso_o); // R7

  AST_ISO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en_o) |=> (iso_o == !pwr_en_o)); // R7

  AST_PRST_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en_o) |=> prst_o); // R6

  AST_PRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    prst_o |=> !prst_o); // R6

  AST_PRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    prst_o |-> $past(iso_o)); // R6

endmodule

bind pgc_top pgc_checker u_chk (
  .clk      (clk),
  .rst_n    (sys_rst_n),
  .mode_i   (mode_i),
  .ctl_q    (ctl_q),
  .pwr_en_o (pwr_en_o),
  .clk_en_o (clk_en_o),
  .iso_o    (iso_o),
  .prst_o   (prst_o)
);

// File: tb/tb_pgc_top.sv
module tb_pgc_top;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_i;
  logic        bus_wr_i;
  logic [3:0]  bus_addr_i;
  logic [31:0] bus_wdata_i;
  logic [31:0] bus_rdata_o;
  logic        pwr_en_o, clk_en_o, iso_o, prst_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgc_top dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .pwr_en_o    (pwr_en_o),
    .clk_en_o    (clk_en_o),
    .iso_o       (iso_o),
    .prst_o      (prst_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a falling edge; write is sampled by the next rising edge.
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd_check(input logic [3:0] a, input logic [31:0] exp, input string req);
    bus_addr_i = a;
    #1;
    check(bus_rdata_o == exp, req, bus_rdata_o, exp);
  endtask

  task automatic cfg(input logic [2:0] g, input logic p);
    wr(4'h0, {31'd0, g[0]});
    wr(4'h4, {31'd0, g[1]});
    wr(4'h8, {31'd0, g[2]});
    wr(4'hC, {31'd0, p});
  endtask

  function automatic logic sel_of(input logic [2:0] g, input logic [1:0] m);
    return (m == 2'b01) ? g[1] : (m == 2'b10) ? g[2] : g[0];
  endfunction

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_i = 2'b00; bus_wr_i = 1'b0;
    bus_addr_i = 4'h0; bus_wdata_i = '0;
    repeat (3) @(negedge clk);
    // R9: output values while held in reset
    check(pwr_en_o == 1'b1 && clk_en_o == 1'b0 && iso_o == 1'b0 && prst_o == 1'b0,
          "R9 reset outputs", {pwr_en_o, clk_en_o, iso_o, prst_o}, 4'b1000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(pwr_en_o == 1'b1 && clk_en_o == 1'b0 && iso_o == 1'b0 && prst_o == 1'b0,
          "R9 outputs after reset", {pwr_en_o, clk_en_o, iso_o, prst_o}, 4'b1000);
    rd_check(4'h0, 32'h0, "R9 run gate reset");
    rd_check(4'h4, 32'h0, "R9 sleep gate reset");
    rd_check(4'h8, 32'h0, "R9 deep gate reset");
    rd_check(4'hC, 32'h1, "R9 keep-power reset");
    @(negedge clk);

    // R8: only bit 0 stored, upper bits ignored, registers independent
    for (int r = 0; r < 4; r++) begin
      wr(4'(r * 4), 32'hFFFF_FFFF);
      rd_check(4'(r * 4), 32'h1, "R8 all-ones write reads one");
      for (int o = 0; o < 4; o++)
        if (o != r)
          rd_check(4'(o * 4), (o == 3) ? 32'h1 : 32'h0, "R8 neighbour untouched");
      wr(4'(r * 4), 32'hFFFF_FFFE);
      rd_check(4'(r * 4), 32'h0, "R8 upper bits ignored");
      @(negedge clk);
    end
    wr(4'hC, 32'h1);

    // R1..R7: every register setting, every mode-to-mode step
    for (int g = 0; g < 8; g++) begin
      for (int p = 0; p < 2; p++) begin
        for (int m1 = 0; m1 < 4; m1++) begin
          for (int m2 = 0; m2 < 4; m2++) begin
            logic pa, ca, pb, cb, sa, sb;
            mode_i = 2'(m1);
            cfg(3'(g), 1'(p));
            repeat (4) @(negedge clk);
            sa = sel_of(3'(g), 2'(m1)); sb = sel_of(3'(g), 2'(m2));
            pa = sa | 1'(p); ca = sa;
            pb = sb | 1'(p); cb = sb;
            check(pwr_en_o == pa && clk_en_o == ca, "R1 settled enables",
                  {pwr_en_o, clk_en_o}, {pa, ca});
            mode_i = 2'(m2);
            #(CLK_PERIOD/4);
            check(pwr_en_o == pa && clk_en_o == ca, "R5 no change before edge",
                  {pwr_en_o, clk_en_o}, {pa, ca});
            @(negedge clk);
            if (sb)
              check(pwr_en_o && clk_en_o, "R2 gate set runs", {pwr_en_o, clk_en_o}, 2'b11);
            else if (p == 0)
              check(!pwr_en_o && !clk_en_o, "R3 fully off", {pwr_en_o, clk_en_o}, 2'b00);
            else
              check(pwr_en_o && !clk_en_o, "R4 retained unclocked", {pwr_en_o, clk_en_o}, 2'b10);
            check(iso_o == (!pb || !pa), "R7 isolation at edge", iso_o, !pb || !pa);
            check(prst_o == 1'b0, "R6 no pulse at rise cycle", prst_o, 1'b0);
            @(negedge clk);
            check(prst_o == (pb && !pa), "R6 pulse after rise", prst_o, pb && !pa);
            check(iso_o == !pb, "R7 isolation release", iso_o, !pb);
            @(negedge clk);
            check(prst_o == 1'b0, "R6 pulse single cycle", prst_o, 1'b0);
          end
        end
      end
    end

    // R10: keep-power write alone restores power and pulses reset
    for (int m = 0; m < 4; m++) begin
      mode_i = 2'(m);
      cfg(3'b000, 1'b0);
      repeat (3) @(negedge clk);
      check(!pwr_en_o && iso_o, "R10 off before write", {pwr_en_o, iso_o}, 2'b01);
      wr(4'hC, 32'h1);
      check(!pwr_en_o, "R10 register stage", pwr_en_o, 1'b0);
      @(negedge clk);
      check(pwr_en_o && !clk_en_o && iso_o && !prst_o, "R10 powered unclocked",
            {pwr_en_o, clk_en_o, iso_o, prst_o}, 4'b1010);
      @(negedge clk);
      check(prst_o && !iso_o, "R10 reset pulse", {prst_o, iso_o}, 2'b10);
      @(negedge clk);
      check(!prst_o && pwr_en_o, "R10 pulse ends", {prst_o, pwr_en_o}, 2'b01);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule